// File: doc/BRIEF.md
# Memory-Mapped Network Interface

This block sits between a processor's memory-mapped bus and the local port of a mesh router. Toward the processor it presents two registers: a data register and a status register. Writing the data register appends one flit to an outgoing packet buffer. Reading the data register removes one flit from an incoming packet buffer. Reading the status register returns buffer occupancy, readiness and error flags.

Both buffers hold exactly one packet of `PKT_LEN` flits, because every packet on the network has the same length. The outgoing buffer starts injecting only once a whole packet has been written. It then sends the flits in write order, using a request/acknowledge handshake in which each flit takes at least two cycles. The incoming buffer accepts flits from the router with the same handshake. When the last flit of a packet has been stored, the block raises an interrupt and stops acknowledging the router. It resumes only after the processor has read every flit, so an unread packet is never overwritten.

The active-low reset is applied asynchronously and released through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `mm_noc_adapter`

## Requirements
- R1: After reset, `irq`, `tx_req` and `rx_ack` are low, and a status read returns only the outgoing-empty bit (bit 17) set.
- R2: A bus write with `bus_sel`=1, `bus_wr`=1 and `bus_addr`=0 appends `bus_wdata` to the outgoing buffer. `tx_req` stays low until `PKT_LEN` flits have been written, and the status outgoing-full bit (bit 16) is then set.
- R3: Outgoing flits appear on `tx_data` in write order. A flit is taken at the rising edge where both `tx_req` and `tx_ack` are high. While `tx_req` is high and `tx_ack` is low, `tx_req` and `tx_data` hold. After each taken flit, `tx_req` is low for at least one cycle.
- R4: Once the last flit of the outgoing packet has been taken, the status outgoing-empty bit (17) is set and the outgoing-full bit (16) is clear.
- R5: The block raises `rx_ack` for exactly one cycle, in the cycle after it sees `rx_req`, provided it has room. The flit on `rx_data` is stored at the edge where both `rx_req` and `rx_ack` are high.
- R6: `irq` and the status packet-ready bit (18) go high at the edge that stores the `PKT_LEN`-th incoming flit, and not before.
- R7: While a complete incoming packet is unread, `rx_ack` stays low whatever `rx_req` does.
- R8: A read with `bus_sel`=1, `bus_wr`=0 and `bus_addr`=0 returns the oldest unread incoming flit, zero-extended, on `bus_rdata` from the next rising edge on. The incoming flit count in status bits [15:0] falls by one.
- R9: Reading the last flit of a packet clears `irq` and bit 18, sets the count to zero, and lets the router deliver again.
- R10: A data write while the outgoing buffer is full is ignored: the flits sent are unchanged, and sticky status bit 19 is set.
- R11: A data read while the incoming buffer is empty returns zero, changes no state, and sets sticky status bit 20.
- R12: A bus write to `bus_addr`=1 clears status bits 19 and 20.
- R13: A status read (`bus_addr`=1, `bus_wr`=0) returns the incoming flit count in bits [15:0], outgoing-full in bit 16, outgoing-empty in bit 17, packet-ready in bit 18, write-error in bit 19 and read-error in bit 20, with all other bits zero. The value shown is the state before that access's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | FLIT_W | Write data (outgoing flit) |
| bus_rdata | output | BUS_W | Registered read data |
| irq | output | 1 | High while a complete incoming packet is held |
| tx_data | output | FLIT_W | Outgoing flit to the router |
| tx_req | output | 1 | Outgoing flit valid request |
| tx_ack | input | 1 | Router accepts the outgoing flit |
| rx_data | input | FLIT_W | Incoming flit from the router |
| rx_req | input | 1 | Router offers an incoming flit |
| rx_ack | output | 1 | Block accepts the incoming flit |

## Verification
The outgoing path is driven with three distinct flit patterns. The router-side acknowledge is delayed by zero, one and two cycles, which separates a correct hold-and-gap handshake from one that drops or repeats a flit. One of these packets also receives an extra write while full, so an error that corrupts the stream is told apart from one that only sets the flag. The incoming path is driven with three packets of different contents. The last one has a further flit already pending while it is unread, so withholding the acknowledge and resuming it after the final read are both observed, along with read ordering across the packet boundary. Empty reads and flag clearing are exercised straight after reset.

// File: rtl/ni_pkg.sv
package ni_pkg;
  // status word layout
  localparam int unsigned ST_CNT_W     = 16;
  localparam int unsigned ST_OUT_FULL  = 16;
  localparam int unsigned ST_OUT_EMPTY = 17;
  localparam int unsigned ST_IN_READY  = 18;
  localparam int unsigned ST_ERR_WR    = 19;
  localparam int unsigned ST_ERR_RD    = 20;

  typedef enum logic {
    REG_DATA   = 1'b0,
    REG_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ni_tx_buf.sv
module ni_tx_buf #(
  parameter int unsigned FLIT_W  = 16,
  parameter int unsigned PKT_LEN = 128
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              push,
  input  logic [FLIT_W-1:0] push_data,
  output logic              full,
  output logic              empty,
  output logic [FLIT_W-1:0] tx_data,
  output logic              tx_req,
  input  logic              tx_ack
);
  localparam int unsigned IDX_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam int unsigned CNT_W = $clog2(PKT_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  logic [FLIT_W-1:0] mem [PKT_LEN];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic              req_q, req_d;
  logic              push_ok;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign tx_data = mem[ptr_q];
  assign tx_req  = req_q;

  always_comb begin
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    req_d = req_q;
    if (push_ok) cnt_d = cnt_q + 1'b1;
    if (req_q && tx_ack) begin
      req_d = 1'b0;
      if (ptr_q == LAST_IDX) begin
        ptr_d = '0;
        cnt_d = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end else if (!req_q && full) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[cnt_q[IDX_W-1:0]] <= push_data;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_req && !tx_ack) |=> (tx_req && $stable(tx_data)));
  p_req_gap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_req && tx_ack) |=> !tx_req);
  p_req_whole_pkt_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_req |-> full);
endmodule

// File: rtl/ni_rx_buf.sv
module ni_rx_buf #(
  parameter int unsigned FLIT_W  = 16,
  parameter int unsigned PKT_LEN = 128
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic [FLIT_W-1:0]            rx_data,
  input  logic                         rx_req,
  output logic                         rx_ack,
  input  logic                         pop,
  output logic [FLIT_W-1:0]            pop_data,
  output logic [$clog2(PKT_LEN+1)-1:0] count,
  output logic                         pkt_ready
);
  localparam int unsigned IDX_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam int unsigned CNT_W = $clog2(PKT_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PKT_LEN - 1);

  logic [FLIT_W-1:0] mem [PKT_LEN];
  logic [CNT_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic              ack_q, ack_d, rdy_q, rdy_d;
  logic              store, pop_ok, space;

  assign space     = (wr_q != FULL_CNT);
  assign store     = rx_req && ack_q;
  assign count     = wr_q - rd_q;
  assign pop_ok    = pop && (count != '0);
  assign pop_data  = mem[rd_q[IDX_W-1:0]];
  assign rx_ack    = ack_q;
  assign pkt_ready = rdy_q;

  always_comb begin
    ack_d = rx_req && !ack_q && space;
    wr_d  = store ? wr_q + 1'b1 : wr_q;
    rd_d  = pop_ok ? rd_q + 1'b1 : rd_q;
    rdy_d = rdy_q;
    if (store && (wr_q == LAST_CNT)) rdy_d = 1'b1;
    if (pop_ok && (rd_q == LAST_CNT)) begin
      wr_d  = '0;
      rd_d  = '0;
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ack_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      ack_q <= ack_d;
      rdy_q <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[wr_q[IDX_W-1:0]] <= rx_data;
  end

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_ack |=> !rx_ack);
  p_ack_withheld_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    pkt_ready |-> !rx_ack);
  p_ready_after_store_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pkt_ready) |-> $past(rx_req && rx_ack));
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    count <= FULL_CNT);
endmodule

// File: rtl/mm_noc_adapter.sv
module mm_noc_adapter
  import ni_pkg::*;
#(
  parameter int unsigned FLIT_W  = 16,
  parameter int unsigned PKT_LEN = 128,
  parameter int unsigned BUS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [FLIT_W-1:0] bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic [FLIT_W-1:0] tx_data,
  output logic              tx_req,
  input  logic              tx_ack,
  input  logic [FLIT_W-1:0] rx_data,
  input  logic              rx_req,
  output logic              rx_ack
);
  localparam int unsigned CNT_W = $clog2(PKT_LEN + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_data, rd_data, wr_stat, rd_stat;
  logic              out_full, out_empty, in_ready, in_empty;
  logic [CNT_W-1:0]  in_count;
  logic [FLIT_W-1:0] pop_data;
  logic              err_wr_q, err_wr_d, err_rd_q, err_rd_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d, status;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_data  = bus_sel && bus_wr  && (bus_addr == REG_DATA);
  assign rd_data  = bus_sel && !bus_wr && (bus_addr == REG_DATA);
  assign wr_stat  = bus_sel && bus_wr  && (bus_addr == REG_STATUS);
  assign rd_stat  = bus_sel && !bus_wr && (bus_addr == REG_STATUS);
  assign in_empty = (in_count == '0);

  ni_tx_buf #(.FLIT_W(FLIT_W), .PKT_LEN(PKT_LEN)) u_tx (
    .clk(clk), .rst_ni(rst_int_n), .push(wr_data), .push_data(bus_wdata),
    .full(out_full), .empty(out_empty), .tx_data(tx_data), .tx_req(tx_req),
    .tx_ack(tx_ack)
  );

  ni_rx_buf #(.FLIT_W(FLIT_W), .PKT_LEN(PKT_LEN)) u_rx (
    .clk(clk), .rst_ni(rst_int_n), .rx_data(rx_data), .rx_req(rx_req),
    .rx_ack(rx_ack), .pop(rd_data), .pop_data(pop_data), .count(in_count),
    .pkt_ready(in_ready)
  );

  always_comb begin
    status                  = '0;
    status[CNT_W-1:0]       = in_count;
    status[ST_OUT_FULL]     = out_full;
    status[ST_OUT_EMPTY]    = out_empty;
    status[ST_IN_READY]     = in_ready;
    status[ST_ERR_WR]       = err_wr_q;
    status[ST_ERR_RD]       = err_rd_q;
  end

  always_comb begin
    err_wr_d = wr_stat ? 1'b0 : (err_wr_q || (wr_data && out_full));
    err_rd_d = wr_stat ? 1'b0 : (err_rd_q || (rd_data && in_empty));
    rdata_d  = rdata_q;
    if (rd_stat) begin
      rdata_d = status;
    end else if (rd_data) begin
      rdata_d = '0;
      if (!in_empty) rdata_d[FLIT_W-1:0] = pop_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_wr_q <= 1'b0;
      err_rd_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      err_wr_q <= err_wr_d;
      err_rd_q <= err_rd_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = in_ready;

  p_empty_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_data && in_empty) |=> (bus_rdata == '0 && err_rd_q));
  p_full_write_flag_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_data && out_full && !wr_stat) |=> err_wr_q);
  p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stat |=> (!err_wr_q && !err_rd_q));
  p_irq_blocks_ack_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> !rx_ack);
endmodule

// File: tb/sim_mm_noc_adapter.sv
module sim_mm_noc_adapter;
  localparam int FW = 8;
  localparam int PL = 4;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [FW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          irq, tx_req, rx_ack;
  logic [FW-1:0] tx_data;
  logic          tx_ack = 1'b0, rx_req = 1'b0;
  logic [FW-1:0] rx_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mm_noc_adapter #(.FLIT_W(FW), .PKT_LEN(PL), .BUS_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_data(tx_data), .tx_req(tx_req), .tx_ack(tx_ack),
    .rx_data(rx_data), .rx_req(rx_req), .rx_ack(rx_ack)
  );

  function automatic logic [FW-1:0] flit(input int p, input int j);
    return FW'(p * 53 + j * 29 + 7);
  endfunction

  function automatic logic [31:0] st(input int cnt, input bit of, input bit oe,
                                     input bit rdy, input bit ew, input bit er);
    return 32'(cnt) | (32'(of) << 16) | (32'(oe) << 17) | (32'(rdy) << 18)
         | (32'(ew) << 19) | (32'(er) << 20);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic bus_acc(input bit wr, input bit a, input logic [FW-1:0] d,
                         output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    q = bus_rdata;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic take_tx(input logic [FW-1:0] exp, input int dly);
    int k = 0;
    while (!tx_req && k < 50) begin @(negedge clk); k++; end
    check("R3 req", 32'(tx_req), 32'd1);
    check("R3 order", 32'(tx_data), 32'(exp));
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      check("R3 hold", {tx_req, tx_data}, {1'b1, exp});
    end
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
    check("R3 gap", 32'(tx_req), 32'd0);
  endtask

  task automatic send_rx(input logic [FW-1:0] d);
    int k = 0;
    @(negedge clk);
    rx_req = 1'b1; rx_data = d;
    while (!rx_ack && k < 50) begin @(negedge clk); k++; end
    check("R5 ack", 32'(rx_ack), 32'd1);
    @(negedge clk);
    check("R5 pulse", 32'(rx_ack), 32'd0);
    rx_req = 1'b0;
  endtask

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R13 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 tx_req", 32'(tx_req), 32'd0);
    check("R1 rx_ack", 32'(rx_ack), 32'd0);
    bus_acc(1'b0, 1'b1, '0, q);
    check("R1 R13 status", q, st(0, 0, 1, 0, 0, 0));

    // R11 empty read, R12 clear
    bus_acc(1'b0, 1'b0, '0, q);
    check("R11 data", q, 32'd0);
    bus_acc(1'b0, 1'b1, '0, q);
    check("R11 flag", q, st(0, 0, 1, 0, 0, 1));
    bus_acc(1'b1, 1'b1, '0, q);
    bus_acc(1'b0, 1'b1, '0, q);
    check("R12 clear", q, st(0, 0, 1, 0, 0, 0));

    // outgoing sweep
    for (int p = 0; p < 3; p++) begin
      for (int j = 0; j < PL; j++) begin
        bus_acc(1'b1, 1'b0, flit(p, j), q);
        if (j < PL - 1) check("R2 no early req", 32'(tx_req), 32'd0);
      end
      bus_acc(1'b0, 1'b1, '0, q);
      check("R2 full", q, st(0, 1, 0, 0, 0, 0));
      if (p == 1) begin
        bus_acc(1'b1, 1'b0, 8'hEE, q);
        bus_acc(1'b0, 1'b1, '0, q);
        check("R10 flag", q, st(0, 1, 0, 0, 1, 0));
      end
      for (int j = 0; j < PL; j++) take_tx(flit(p, j), p);
      bus_acc(1'b0, 1'b1, '0, q);
      check("R4 empty", q, st(0, 0, 1, 0, (p == 1), 0));
      if (p == 1) bus_acc(1'b1, 1'b1, '0, q);
    end

    // incoming sweep
    for (int p = 0; p < 3; p++) begin
      int b = 10 + p;
      for (int j = 0; j < PL; j++) begin
        send_rx(flit(b, j));
        check(j < PL - 1 ? "R6 early" : "R6 irq", 32'(irq), 32'(j == PL - 1));
      end
      bus_acc(1'b0, 1'b1, '0, q);
      check("R13 ready", q, st(PL, 0, 1, 1, 0, 0));
      if (p == 2) begin
        @(negedge clk);
        rx_req = 1'b1; rx_data = 8'hA5;
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          check("R7 withheld", 32'(rx_ack), 32'd0);
        end
      end
      for (int j = 0; j < PL; j++) begin
        bus_acc(1'b0, 1'b0, '0, q);
        check("R8 data", q, 32'(flit(b, j)));
        if (j == 1) begin
          bus_acc(1'b0, 1'b1, '0, q);
          check("R8 count", q, st(PL - 2, 0, 1, 1, 0, 0));
        end
      end
      check("R9 irq", 32'(irq), 32'd0);
      if (p == 2) begin
        int k = 0;
        while (!rx_ack && k < 20) begin @(negedge clk); k++; end
        check("R9 resume", 32'(rx_ack), 32'd1);
        @(negedge clk);
        rx_req = 1'b0;
        bus_acc(1'b0, 1'b1, '0, q);
        check("R9 count", q, st(1, 0, 1, 0, 0, 0));
        bus_acc(1'b0, 1'b0, '0, q);
        check("R8 carried", q, 32'h0000_00A5);
      end else begin
        bus_acc(1'b0, 1'b1, '0, q);
        check("R9 freed", q, st(0, 0, 1, 0, 0, 0));
      end
    end

    finish_run();
  end
endmodule